// File: doc/BRIEF.md
# Table-Driven Power Sequencing Engine

This block steps a board through its power-up, power-down and fault-handling states. It drives eight power-enable lines. The order of states, the enable pattern of each state and the input conditions that move it from one state to the next all come from a configuration table that is written before the engine is armed. No sequence is built into the logic.

The engine watches two groups of inputs: supply-good flags from the voltage fault detectors and general-purpose digital inputs. Both groups pass through a two-stage synchronizer, and the synchronized values form one input vector. Each table entry holds two guarded transitions. Each transition has a mask, a compare value, a target state and an enable bit. The primary transition wins over the alternate one.

One state can be named as the black-box state. Each time the engine enters that state from another state, it presents an eight-byte record for one cycle. The record describes the state being left, the inputs that caused the move and the enables that were driven at that moment. A separate non-volatile store can then keep it.

Top module: `pseq_engine`

## Requirements
- R1: After reset, `cur_state` is 0, `pwr_en` is all zeros and `rec_valid` is low.
- R2: While `cfg_done` is low, the state is forced to 0 and `pwr_en` to zero, whatever the inputs and table contents are.
- R3: With an all-zero table, the state stays at 0 and every enable stays low, even after `cfg_done` is high and any input is applied.
- R4: The input vector is {gpi, sup_ok}, with supply flags in bits 0..3 and digital inputs in bits 4..7. An input change applied between clock edges first affects the state on the third rising edge after the change.
- R5: An entry is laid out LSB first as follows: enable pattern [7:0], primary mask [15:8], primary value [23:16], alternate mask [31:24], alternate value [39:32], primary target [43:40], alternate target [47:44], primary enable [48], alternate enable [49]. A transition is true when its enable bit is set and the input matches the value on every masked bit. `pwr_en` changes on the same edge as `cur_state` and shows the pattern of the new state.
- R6: When only the alternate transition is true, the engine moves to the alternate target.
- R7: When both transitions are true, the engine moves to the primary target.
- R8: When neither transition is true, the state and enables hold.
- R9: When `bb_en` is high and the engine moves from another state into `bb_state`, `rec_valid` pulses for exactly one cycle. It pulses on the edge where the state enters `bb_state`. `rec_data` then carries the following bytes:
  - byte 0: the state that was left
  - byte 1: the synchronized input vector
  - byte 2: the enables in force before the move
  - byte 3: the cause code (1 = primary, 2 = alternate)
  - bytes 4 to 7: zero
- R10: No record is produced while `bb_en` is low, or while the engine loops inside `bb_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry index to write |
| cfg_wdata | input | 50 | Entry word (layout in R5) |
| cfg_done | input | 1 | Table loaded; arms the engine |
| bb_en | input | 1 | Enables record capture |
| bb_state | input | 4 | Index of the black-box state |
| sup_ok | input | 4 | Supply-good flags (asynchronous) |
| gpi | input | 4 | General-purpose digital inputs (asynchronous) |
| pwr_en | output | 8 | Power-enable outputs |
| cur_state | output | 4 | Current state index |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_data | output | 64 | Eight-byte fault record |

## Verification
The embedded properties check three things on every cycle:
- The engine is held at state 0 with low enables while it is unarmed.
- The primary target wins when both guards are true, the alternate target is taken otherwise, and the state holds when no guard is true.
- The record strobe is a single cycle and always coincides with arrival in the black-box state.

Some behaviour is visible only through the bench's directed scenarios:
- the three-edge input latency
- the exact byte contents of each record
- multi-step walks through a programmed sequence
- silence of the record port during self-loops and while capture is off

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    // Cause codes placed in byte 3 of a fault record.
    typedef enum logic [7:0] {
        CAUSE_NONE = 8'd0,
        CAUSE_PRI  = 8'd1,
        CAUSE_ALT  = 8'd2
    } cause_e;

    localparam int REC_BYTES = 8;
    localparam int REC_W     = REC_BYTES * 8;

    // Zero-extend or truncate a value into one record byte.
    function automatic logic [7:0] to_byte(input logic [31:0] v);
        return v[7:0];
    endfunction

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/pseq_cfg_ram.sv
module pseq_cfg_ram #(
    parameter int N_ST = 16,
    parameter int EW   = 50,
    parameter int SW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    input  logic [SW-1:0] rd_addr_a,
    output logic [EW-1:0] rd_data_a,
    input  logic [SW-1:0] rd_addr_b,
    output logic [EW-1:0] rd_data_b
);

    logic [EW-1:0] mem_d [N_ST];
    logic [EW-1:0] mem_q [N_ST];

    always_comb begin
        for (int i = 0; i < N_ST; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && (int'(wr_addr) < N_ST)) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ST; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ST; i++) mem_q[i] <= mem_d[i];
        end
    end

    // Out-of-range reads return an all-zero entry, which is inert.
    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        if (int'(rd_addr_a) < N_ST) rd_data_a = mem_q[rd_addr_a];
        if (int'(rd_addr_b) < N_ST) rd_data_b = mem_q[rd_addr_b];
    end

endmodule

// File: rtl/pseq_cond.sv
module pseq_cond #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8,
    parameter int SW    = 4,
    parameter int EW    = N_OUT + 4 * N_IN + 2 * SW + 2
) (
    input  logic [EW-1:0]    entry,
    input  logic [N_IN-1:0]  in_vec,
    output logic             pri_hit,
    output logic             alt_hit,
    output logic [SW-1:0]    pri_next,
    output logic [SW-1:0]    alt_next
);

    localparam int O_PM = N_OUT;
    localparam int O_PV = O_PM + N_IN;
    localparam int O_AM = O_PV + N_IN;
    localparam int O_AV = O_AM + N_IN;
    localparam int O_PN = O_AV + N_IN;
    localparam int O_AN = O_PN + SW;
    localparam int O_PE = O_AN + SW;
    localparam int O_AE = O_PE + 1;

    logic [N_IN-1:0] pm, pv, am, av;
    logic            pe, ae;

    always_comb begin
        pm       = entry[O_PM +: N_IN];
        pv       = entry[O_PV +: N_IN];
        am       = entry[O_AM +: N_IN];
        av       = entry[O_AV +: N_IN];
        pri_next = entry[O_PN +: SW];
        alt_next = entry[O_AN +: SW];
        pe       = entry[O_PE];
        ae       = entry[O_AE];
        pri_hit  = pe && (((in_vec ^ pv) & pm) == '0);
        alt_hit  = ae && (((in_vec ^ av) & am) == '0);
    end

endmodule

// File: rtl/pseq_engine.sv
module pseq_engine #(
    parameter int N_ST  = 16,
    parameter int N_OUT = 8,
    parameter int N_SUP = 4,
    parameter int N_GPI = 4,
    localparam int N_IN = N_SUP + N_GPI,
    localparam int SW   = $clog2(N_ST),
    localparam int EW   = N_OUT + 4 * N_IN + 2 * SW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SW-1:0]     cfg_addr,
    input  logic [EW-1:0]     cfg_wdata,
    input  logic              cfg_done,
    input  logic              bb_en,
    input  logic [SW-1:0]     bb_state,
    input  logic [N_SUP-1:0]  sup_ok,
    input  logic [N_GPI-1:0]  gpi,
    output logic [N_OUT-1:0]  pwr_en,
    output logic [SW-1:0]     cur_state,
    output logic              rec_valid,
    output logic [63:0]       rec_data
);
    import pseq_pkg::*;

    typedef struct packed {
        logic [SW-1:0]    state;
        logic [N_OUT-1:0] en;
        logic             rec_valid;
        logic [REC_W-1:0] rec_data;
    } eng_t;

    eng_t st_d, st_q;

    logic [N_IN-1:0] in_sync;
    logic [EW-1:0]   cur_entry;
    logic [EW-1:0]   nxt_entry;
    logic            pri_hit, alt_hit;
    logic [SW-1:0]   pri_nxt, alt_nxt;
    logic [SW-1:0]   nxt_state;
    logic            moving;
    cause_e          cause;

    // Input synchronizer: supply flags in the low bits, digital inputs above.
    pseq_sync #(.W(N_IN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({gpi, sup_ok}),
        .sync_out (in_sync)
    );

    pseq_cfg_ram #(.N_ST(N_ST), .EW(EW), .SW(SW)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_addr_a (st_q.state),
        .rd_data_a (cur_entry),
        .rd_addr_b (nxt_state),
        .rd_data_b (nxt_entry)
    );

    pseq_cond #(.N_IN(N_IN), .N_OUT(N_OUT), .SW(SW), .EW(EW)) u_cond (
        .entry    (cur_entry),
        .in_vec   (in_sync),
        .pri_hit  (pri_hit),
        .alt_hit  (alt_hit),
        .pri_next (pri_nxt),
        .alt_next (alt_nxt)
    );

    // Transition selection: the primary guard has priority.
    always_comb begin
        nxt_state = st_q.state;
        moving    = 1'b0;
        cause     = CAUSE_NONE;
        if (!cfg_done) begin
            nxt_state = '0;
        end else if (pri_hit) begin
            nxt_state = pri_nxt;
            moving    = 1'b1;
            cause     = CAUSE_PRI;
        end else if (alt_hit) begin
            nxt_state = alt_nxt;
            moving    = 1'b1;
            cause     = CAUSE_ALT;
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.state     = nxt_state;
        st_d.en        = cfg_done ? nxt_entry[N_OUT-1:0] : '0;
        st_d.rec_valid = 1'b0;
        if (cfg_done && bb_en && moving &&
            (nxt_state == bb_state) && (st_q.state != bb_state)) begin
            st_d.rec_valid = 1'b1;
            st_d.rec_data  = {32'h0,
                              8'(cause),
                              to_byte(32'(st_q.en)),
                              to_byte(32'(in_sync)),
                              to_byte(32'(st_q.state))};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwr_en    = st_q.en;
    assign cur_state = st_q.state;
    assign rec_valid = st_q.rec_valid;
    assign rec_data  = st_q.rec_data;

    // R2: an unarmed engine sits in state 0 with all enables low.
    p_unarmed_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> (cur_state == '0) && (pwr_en == '0));

    // R7: the primary guard wins.
    p_primary_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && pri_hit) |=> (cur_state == $past(pri_nxt)));

    // R6: the alternate target is taken when only its guard holds.
    p_alternate_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !pri_hit && alt_hit) |=> (cur_state == $past(alt_nxt)));

    // R8: with no guard true, the state holds.
    p_hold_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !pri_hit && !alt_hit) |=> $stable(cur_state));

    // R9: the record strobe lasts a single cycle.
    p_record_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    // R9: the strobe coincides with arrival in the black-box state.
    p_record_in_bb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_valid) |-> (cur_state == $past(bb_state)) &&
                             (rec_data[7:0] != 8'(cur_state)));

endmodule

// File: tb/pseq_engine_bench.sv
module pseq_engine_bench;

    localparam int EW = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [EW-1:0] cfg_wdata = '0;
    logic          cfg_done = 1'b0;
    logic          bb_en = 1'b1;
    logic [3:0]    bb_state = 4'd5;
    logic [3:0]    sup_ok = '0;
    logic [3:0]    gpi = '0;
    logic [7:0]    pwr_en;
    logic [3:0]    cur_state;
    logic          rec_valid;
    logic [63:0]   rec_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    pseq_engine u_pseq_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_done  (cfg_done),
        .bb_en     (bb_en),
        .bb_state  (bb_state),
        .sup_ok    (sup_ok),
        .gpi       (gpi),
        .pwr_en    (pwr_en),
        .cur_state (cur_state),
        .rec_valid (rec_valid),
        .rec_data  (rec_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [7:0] v);
        sup_ok = v[3:0];
        gpi    = v[7:4];
    endtask

    function automatic logic [EW-1:0] mk(input logic [7:0] o,
        input logic [7:0] pm, input logic [7:0] pv,
        input logic [7:0] am, input logic [7:0] av,
        input logic [3:0] pn, input logic [3:0] an,
        input logic pe, input logic ae);
        return {ae, pe, an, pn, av, am, pv, pm, o};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [EW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    function automatic logic [63:0] rec(input logic [7:0] prev,
        input logic [7:0] inv, input logic [7:0] en, input logic [7:0] c);
        return {32'h0, c, en, inv, prev};
    endfunction

    task automatic t_reset();
        chk("R1", "state", 64'(cur_state), 64'd0);
        chk("R1", "pwr_en", 64'(pwr_en), 64'd0);
        chk("R1", "rec_valid", 64'(rec_valid), 64'd0);
    endtask

    task automatic t_zero_table();
        cfg_done = 1'b1;
        drive(8'hFF);
        step(5);
        chk("R3", "state", 64'(cur_state), 64'd0);
        chk("R3", "pwr_en", 64'(pwr_en), 64'd0);
        drive(8'h01);
        step(4);
        chk("R3", "pwr_en after change", 64'(pwr_en), 64'd0);
        cfg_done = 1'b0;
        step(1);
    endtask

    task automatic t_program_unarmed();
        // S0 idle: leave when supply 0 good and digital input 0 low.
        wr(4'd0, mk(8'h00, 8'h11, 8'h01, 8'h00, 8'h00, 4'd1, 4'd0, 1'b1, 1'b0));
        wr(4'd1, mk(8'h01, 8'h02, 8'h02, 8'h01, 8'h00, 4'd2, 4'd5, 1'b1, 1'b1));
        wr(4'd2, mk(8'h03, 8'h04, 8'h04, 8'h01, 8'h00, 4'd3, 4'd5, 1'b1, 1'b1));
        wr(4'd3, mk(8'h07, 8'h20, 8'h20, 8'h01, 8'h00, 4'd4, 4'd5, 1'b1, 1'b1));
        wr(4'd4, mk(8'hFF, 8'h40, 8'h40, 8'h01, 8'h00, 4'd0, 4'd5, 1'b1, 1'b1));
        // S5 black box: exit on digital input 3, otherwise loop on itself.
        wr(4'd5, mk(8'h80, 8'h80, 8'h80, 8'h00, 8'h00, 4'd0, 4'd5, 1'b1, 1'b1));
        step(4);
        chk("R2", "state while unarmed", 64'(cur_state), 64'd0);
        chk("R2", "pwr_en while unarmed", 64'(pwr_en), 64'd0);
    endtask

    task automatic t_arm_and_latency();
        cfg_done = 1'b1;
        step(1);
        chk("R5", "state after arm", 64'(cur_state), 64'd1);
        chk("R5", "pattern of S1", 64'(pwr_en), 64'h01);
        drive(8'h03);
        step(2);
        chk("R4", "state after two edges", 64'(cur_state), 64'd1);
        step(1);
        chk("R4", "state on third edge", 64'(cur_state), 64'd2);
        chk("R5", "pattern of S2", 64'(pwr_en), 64'h03);
    endtask

    task automatic t_hold();
        step(4);
        chk("R8", "state held", 64'(cur_state), 64'd2);
        chk("R8", "pwr_en held", 64'(pwr_en), 64'h03);
        chk("R8", "no record", 64'(rec_valid), 64'd0);
    endtask

    task automatic t_alt_record();
        drive(8'h02);
        step(3);
        chk("R6", "alternate target", 64'(cur_state), 64'd5);
        chk("R9", "rec_valid", 64'(rec_valid), 64'd1);
        chk("R9", "rec_data", rec_data, rec(8'd2, 8'h02, 8'h03, 8'd2));
        step(1);
        chk("R9", "strobe one cycle", 64'(rec_valid), 64'd0);
        step(3);
        chk("R10", "self-loop state", 64'(cur_state), 64'd5);
        chk("R10", "no record in loop", 64'(rec_valid), 64'd0);
    endtask

    task automatic t_exit_bb();
        drive(8'h80);
        step(3);
        chk("R5", "exit to S0", 64'(cur_state), 64'd0);
        chk("R5", "pattern of S0", 64'(pwr_en), 64'h00);
    endtask

    task automatic t_walk_and_priority();
        drive(8'h07);
        step(3);
        chk("R5", "walk S1", 64'(cur_state), 64'd1);
        step(1);
        chk("R5", "walk S2", 64'(cur_state), 64'd2);
        step(1);
        chk("R5", "walk S3", 64'(cur_state), 64'd3);
        chk("R5", "pattern of S3", 64'(pwr_en), 64'h07);
        drive(8'h26);
        step(3);
        chk("R7", "primary wins", 64'(cur_state), 64'd4);
        chk("R7", "pattern of S4", 64'(pwr_en), 64'hFF);
        chk("R9", "no record yet", 64'(rec_valid), 64'd0);
        step(1);
        chk("R6", "alternate from S4", 64'(cur_state), 64'd5);
        chk("R9", "rec_valid", 64'(rec_valid), 64'd1);
        chk("R9", "rec_data", rec_data, rec(8'd4, 8'h26, 8'hFF, 8'd2));
        step(1);
        chk("R9", "strobe one cycle", 64'(rec_valid), 64'd0);
    endtask

    task automatic t_capture_off();
        bb_en = 1'b0;
        drive(8'h07);
        step(5);
        chk("R10", "walk to S3", 64'(cur_state), 64'd3);
        drive(8'h26);
        step(3);
        chk("R10", "at S4", 64'(cur_state), 64'd4);
        step(1);
        chk("R10", "entered S5", 64'(cur_state), 64'd5);
        chk("R10", "no record when off", 64'(rec_valid), 64'd0);
        bb_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_zero_table();
        t_program_unarmed();
        t_arm_and_latency();
        t_hold();
        t_alt_record();
        t_exit_bb();
        t_walk_and_priority();
        t_exit_bb();
        t_capture_off();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule